// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a two-bank synchronous DRAM. On every rising clock edge it samples the active-low chip select, the row strobe, the column strobe and the write enable, together with a 12-bit address bus. It turns the strobes into one command and checks that command against the state it keeps. That state is which banks are open and which row each one holds, the programmed operating mode, a short lockout after a mode load, and the burst window of a read or write with auto precharge.

An accepted command updates the state. An illegal command raises a one-cycle error strobe and changes nothing. The outputs carry the accepted command, the addressed bank, the auto-precharge flag, the open-bank and open-row state and the mode fields. Every output is registered, so it reflects the command sampled at the previous rising edge. The array, the data path, analog timing and clock gating for power down are outside this block.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With csN high, or with csN low and rasN/casN/weN all high, the block reports cmdOut = 0 (no operation) and errOut = 0, and no bank or mode state changes.
- R2: With csN low, {rasN,casN,weN} decodes as 000 mode load (cmdOut 1), 011 activate (2), 101 read (3), 100 write (4), 010 precharge (5), 110 burst stop (6) and 001 auto refresh (7). An accepted command appears on cmdOut one cycle after it is sampled. Burst stop is always accepted outside the lockout.
- R3: addr[11] selects the bank (0 = bank A, 1 = bank B) for activate, read, write and single-bank precharge, and is reported on bankOut. For a read or write, addr[10] is reported on apOut as the auto-precharge request. bankOut and apOut are 0 for every other result.
- R4: An accepted mode load stores burstLen = addr[2:0], burstType = addr[3], casLat = addr[6:4] and singleWrite = addr[9], and sets modeValid.
- R5: A mode load is illegal if either bank is open or the encoding is reserved. Reserved means addr[8:7] != 0, casLat not 1 to 3, burstLen 4 to 6, or burstLen 7 (full page) with burstType 1.
- R6: For MRS_GAP-1 cycles after an accepted mode load, any command other than no operation is illegal. With the default this is the single next cycle.
- R7: An activate is legal only to an idle bank. It opens that bank and records addr[10:0] as its open row.
- R8: A precharge with addr[10] = 0 closes the bank selected by addr[11]. With addr[10] = 1 it closes both banks, ignores addr[11] and reports bankOut = 0.
- R9: A read or write to an idle bank is illegal.
- R10: After an accepted read or write with auto precharge, every read or write in the next L sampled cycles is illegal. L is the burst length (burstLen 0/1/2/3/7 gives 1/2/4/8/PAGE_LEN), or 1 for a write in single-write mode. The bank closes at the L-th edge. A precharge that closes that bank ends the window at once.
- R11: An auto refresh is legal only when both banks are idle.
- R12: An illegal command gives errOut = 1 for one cycle with cmdOut = 0, bankOut = 0 and apOut = 0, and leaves bank, row and mode state unchanged.
- R13: A synchronous reset closes both banks, clears the rows and mode fields to 0, clears modeValid, the lockout and the burst window, and reports cmdOut = 0 and errOut = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | 12 | Address; bit 11 bank, bit 10 all-banks/auto-precharge |
| cmdOut | output | 3 | Accepted command code, 0 when none |
| errOut | output | 1 | Illegal-command strobe |
| bankOut | output | 1 | Bank of the accepted command |
| apOut | output | 1 | Auto precharge requested by an accepted read/write |
| bankActive | output | 2 | Open flag per bank, bit 0 = bank A |
| rowOpenA | output | 11 | Row recorded for bank A |
| rowOpenB | output | 11 | Row recorded for bank B |
| modeValid | output | 1 | A mode load has been accepted since reset |
| burstLen | output | 3 | Burst length code |
| burstType | output | 1 | 0 sequential, 1 interleaved |
| casLat | output | 3 | Read latency in cycles |
| singleWrite | output | 1 | Writes are single-beat |

## Verification
Every result of this block is due exactly one clock after the rising edge that samples the command, and the lockout and burst-window effects follow from a count of edges after the mode load or auto-precharge access. The driver changes the pins on the falling edge and queues one expected record per cycle, taken from a requirement-level model. The monitor pops that record 2 ns after the next rising edge and compares all outputs at once. The auto-precharge cases place reads and writes at the first, a middle and the last edge of the window, and one just after it, so an off-by-one in the window length shows up.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  localparam int ADDR_W = 12;
  localparam int ROW_W  = 11;
  localparam int CL_W   = 3;
  localparam int BL_W   = 3;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_MRS   = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_BSTOP = 3'd6,
    CMD_REF   = 3'd7
  } cmd_e;

  typedef struct packed {
    cmd_e             cmd;
    logic             err;
    logic             bank;
    logic             autoPre;
    logic             allBanks;
    logic [ROW_W-1:0] row;
    logic [BL_W-1:0]  blCode;
    logic             btSel;
    logic [CL_W-1:0]  clCode;
    logic             swSel;
  } ctrl_strobe_t;
endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int MRS_GAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bankActive,
  input  logic              apBusy,
  output ctrl_strobe_t      strb
);
  localparam int LOCK_N = (MRS_GAP > 1) ? MRS_GAP - 1 : 0;
  localparam int LOCK_W = $clog2(MRS_GAP + 1);

  logic [LOCK_W-1:0] lockLeft;
  cmd_e rawCmd;
  logic legal, mrsBad, tgtActive, bankSel, bothIdle;

  assign bankSel   = addr[ADDR_W-1];
  assign tgtActive = bankActive[bankSel];
  assign bothIdle  = (bankActive == 2'b00);

  always_comb begin
    if (csN) rawCmd = CMD_NOP;
    else begin
      unique case ({rasN, casN, weN})
        3'b000:  rawCmd = CMD_MRS;
        3'b011:  rawCmd = CMD_ACT;
        3'b101:  rawCmd = CMD_READ;
        3'b100:  rawCmd = CMD_WRITE;
        3'b010:  rawCmd = CMD_PRE;
        3'b110:  rawCmd = CMD_BSTOP;
        3'b001:  rawCmd = CMD_REF;
        default: rawCmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    mrsBad = (addr[8:7] != 2'b00) || (addr[6:4] == 3'd0) || (addr[6:4] > 3'd3)
          || (addr[2:0] == 3'd4) || (addr[2:0] == 3'd5) || (addr[2:0] == 3'd6)
          || ((addr[2:0] == 3'd7) && addr[3]);
    unique case (rawCmd)
      CMD_MRS:              legal = bothIdle && !mrsBad;
      CMD_ACT:              legal = !tgtActive;
      CMD_READ, CMD_WRITE:  legal = tgtActive && !apBusy;
      CMD_REF:              legal = bothIdle;
      default:              legal = 1'b1;
    endcase
    if ((lockLeft != '0) && (rawCmd != CMD_NOP)) legal = 1'b0;
  end

  always_comb begin
    strb          = '0;
    strb.cmd      = legal ? rawCmd : CMD_NOP;
    strb.err      = !legal;
    strb.row      = addr[ROW_W-1:0];
    strb.blCode   = addr[2:0];
    strb.btSel    = addr[3];
    strb.clCode   = addr[6:4];
    strb.swSel    = addr[9];
    strb.allBanks = legal && (rawCmd == CMD_PRE) && addr[10];
    strb.autoPre  = legal && ((rawCmd == CMD_READ) || (rawCmd == CMD_WRITE)) && addr[10];
    if (legal && ((rawCmd == CMD_ACT) || (rawCmd == CMD_READ) || (rawCmd == CMD_WRITE)
        || ((rawCmd == CMD_PRE) && !addr[10])))
      strb.bank = bankSel;
  end

  always_ff @(posedge clk) begin
    if (rst) lockLeft <= '0;
    else if (strb.cmd == CMD_MRS) lockLeft <= LOCK_W'(LOCK_N);
    else if (lockLeft != '0) lockLeft <= lockLeft - 1'b1;
  end

  AST_MRS_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (strb.cmd == CMD_MRS) |=> (strb.cmd == CMD_NOP)); // R6
  AST_REF_BOTH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (strb.cmd == CMD_REF) |-> (bankActive == 2'b00)); // R11
endmodule

// File: rtl/sdram_bank_dp.sv
module sdram_bank_dp
  import sdram_cmd_pkg::*;
#(
  parameter int PAGE_LEN = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_strobe_t     strb,
  output logic [2:0]       cmdOut,
  output logic             errOut,
  output logic             bankOut,
  output logic             apOut,
  output logic [1:0]       bankActive,
  output logic [ROW_W-1:0] rowOpenA,
  output logic [ROW_W-1:0] rowOpenB,
  output logic             modeValid,
  output logic [BL_W-1:0]  burstLen,
  output logic             burstType,
  output logic [CL_W-1:0]  casLat,
  output logic             singleWrite,
  output logic             apBusy
);
  localparam int AP_W = $clog2(PAGE_LEN + 1);

  logic [AP_W-1:0]  apLeft, burstCycles;
  logic             apBank;
  logic [ROW_W-1:0] rowReg [2];
  logic             isPre, isRw;

  assign isPre  = (strb.cmd == CMD_PRE);
  assign isRw   = (strb.cmd == CMD_READ) || (strb.cmd == CMD_WRITE);
  assign apBusy = (apLeft != '0);

  always_comb begin
    unique case (burstLen)
      3'd0:    burstCycles = AP_W'(1);
      3'd1:    burstCycles = AP_W'(2);
      3'd2:    burstCycles = AP_W'(4);
      3'd3:    burstCycles = AP_W'(8);
      3'd7:    burstCycles = AP_W'(PAGE_LEN);
      default: burstCycles = AP_W'(1);
    endcase
    if ((strb.cmd == CMD_WRITE) && singleWrite) burstCycles = AP_W'(1);
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic hitMe, apExpire;
    assign hitMe    = (strb.bank == 1'(b));
    assign apExpire = (apLeft == AP_W'(1)) && (apBank == 1'(b));
    always_ff @(posedge clk) begin
      if (rst) begin
        bankActive[b] <= 1'b0;
        rowReg[b]     <= '0;
      end else if ((strb.cmd == CMD_ACT) && hitMe) begin
        bankActive[b] <= 1'b1;
        rowReg[b]     <= strb.row;
      end else if (isPre && (strb.allBanks || hitMe)) begin
        bankActive[b] <= 1'b0;
      end else if (apExpire) begin
        bankActive[b] <= 1'b0;
      end
    end
  end
  assign rowOpenA = rowReg[0];
  assign rowOpenB = rowReg[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      apLeft <= '0;
      apBank <= 1'b0;
    end else if (isRw && strb.autoPre) begin
      apLeft <= burstCycles;
      apBank <= strb.bank;
    end else if (isPre && (strb.allBanks || (strb.bank == apBank))) begin
      apLeft <= '0;
    end else if (apLeft != '0) begin
      apLeft <= apLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeValid   <= 1'b0;
      burstLen    <= '0;
      burstType   <= 1'b0;
      casLat      <= '0;
      singleWrite <= 1'b0;
    end else if (strb.cmd == CMD_MRS) begin
      modeValid   <= 1'b1;
      burstLen    <= strb.blCode;
      burstType   <= strb.btSel;
      casLat      <= strb.clCode;
      singleWrite <= strb.swSel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdOut  <= CMD_NOP;
      errOut  <= 1'b0;
      bankOut <= 1'b0;
      apOut   <= 1'b0;
    end else begin
      cmdOut  <= strb.cmd;
      errOut  <= strb.err;
      bankOut <= strb.bank;
      apOut   <= strb.autoPre;
    end
  end

  AST_MRS_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (strb.cmd == CMD_MRS) |-> (bankActive == 2'b00)); // R5
  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (rst)
    (strb.cmd == CMD_ACT) |=> bankActive[$past(strb.bank)]); // R7
  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (isPre && strb.allBanks) |=> (bankActive == 2'b00)); // R8
  AST_RW_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    isRw |-> (apLeft == '0)); // R10
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (strb.err && (apLeft != AP_W'(1))) |=> ($stable(bankActive) && $stable(modeValid)
      && $stable(burstLen) && $stable(casLat))); // R12
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int PAGE_LEN = 256,
  parameter int MRS_GAP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        cmdOut,
  output logic              errOut,
  output logic              bankOut,
  output logic              apOut,
  output logic [1:0]        bankActive,
  output logic [ROW_W-1:0]  rowOpenA,
  output logic [ROW_W-1:0]  rowOpenB,
  output logic              modeValid,
  output logic [BL_W-1:0]   burstLen,
  output logic              burstType,
  output logic [CL_W-1:0]   casLat,
  output logic              singleWrite
);
  ctrl_strobe_t strb;
  logic         apBusy;

  sdram_cmd_ctrl #(.MRS_GAP(MRS_GAP)) u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .bankActive(bankActive), .apBusy(apBusy), .strb(strb)
  );

  sdram_bank_dp #(.PAGE_LEN(PAGE_LEN)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .cmdOut(cmdOut), .errOut(errOut),
    .bankOut(bankOut), .apOut(apOut), .bankActive(bankActive),
    .rowOpenA(rowOpenA), .rowOpenB(rowOpenB), .modeValid(modeValid),
    .burstLen(burstLen), .burstType(burstType), .casLat(casLat),
    .singleWrite(singleWrite), .apBusy(apBusy)
  );
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  localparam int PAGE = 256;
  localparam int GAP  = 2;
  localparam logic [2:0] K_MRS = 3'b000, K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_BST = 3'b110, K_REF = 3'b001, K_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [11:0] addr = '0;
  logic [2:0] cmdOut, burstLen, casLat;
  logic errOut, bankOut, apOut, modeValid, burstType, singleWrite;
  logic [1:0] bankActive;
  logic [10:0] rowOpenA, rowOpenB;

  always #5 clk = ~clk;

  sdram_cmd_tracker #(.PAGE_LEN(PAGE), .MRS_GAP(GAP)) dut (
    .clk(clk), .rst(rst), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .addr(addr),
    .cmdOut(cmdOut), .errOut(errOut), .bankOut(bankOut), .apOut(apOut),
    .bankActive(bankActive), .rowOpenA(rowOpenA), .rowOpenB(rowOpenB),
    .modeValid(modeValid), .burstLen(burstLen), .burstType(burstType),
    .casLat(casLat), .singleWrite(singleWrite)
  );

  typedef struct {
    string       tag;
    logic [47:0] vec;
  } exp_t;
  exp_t expQ[$];
  int nCmp = 0, nBad = 0;
  bit finished = 0;

  // requirement-level model state
  bit        mAct[2];
  bit [10:0] mRow[2];
  bit        mValid, mBt, mSw, mApBank;
  bit [2:0]  mBl, mCl;
  int        mLock, mAp;

  function automatic logic [47:0] pack(logic [2:0] c, logic e, logic b, logic ap);
    return {c, e, b, ap, mAct[1], mAct[0], mRow[0], mRow[1], mValid, mBl, mBt, mCl, mSw, 9'd0};
  endfunction

  function automatic logic [47:0] actual();
    return {cmdOut, errOut, bankOut, apOut, bankActive, rowOpenA, rowOpenB,
            modeValid, burstLen, burstType, casLat, singleWrite, 9'd0};
  endfunction

  function automatic int decode(logic csn, logic [2:0] rcw);
    if (csn) return 0;
    case (rcw)
      K_MRS: return 1;  K_ACT: return 2;  K_RD:  return 3;  K_WR: return 4;
      K_PRE: return 5;  K_BST: return 6;  K_REF: return 7;  default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    mAct[0] = 0; mAct[1] = 0; mRow[0] = '0; mRow[1] = '0;
    mValid = 0; mBt = 0; mSw = 0; mBl = '0; mCl = '0; mLock = 0; mAp = 0; mApBank = 0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; csN = 1'b1; {rasN, casN, weN} = K_NOP; addr = '0;
    model_reset();
    expQ.push_back('{tag, pack(3'd0, 1'b0, 1'b0, 1'b0)});
  endtask

  task automatic issue(input string tag, input logic csn, input logic [2:0] rcw, input logic [11:0] a);
    int raw, acc, len;
    bit ok, bad, b, expire, eb;
    logic bo, apo;
    @(negedge clk);
    rst = 1'b0; csN = csn; {rasN, casN, weN} = rcw; addr = a;
    raw = decode(csn, rcw);
    b = a[11];
    bad = (a[8:7] != 0) || (a[6:4] == 0) || (a[6:4] > 3) || (a[2:0] >= 4 && a[2:0] <= 6)
       || (a[2:0] == 7 && a[3]);
    case (raw)
      1: ok = !mAct[0] && !mAct[1] && !bad;
      2: ok = !mAct[b];
      3, 4: ok = mAct[b] && (mAp == 0);
      7: ok = !mAct[0] && !mAct[1];
      default: ok = 1;
    endcase
    if (mLock > 0 && raw != 0) ok = 0;
    acc = ok ? raw : 0;
    case (mBl)
      3'd0: len = 1; 3'd1: len = 2; 3'd2: len = 4; 3'd3: len = 8; 3'd7: len = PAGE;
      default: len = 1;
    endcase
    if (acc == 4 && mSw) len = 1;
    expire = (mAp == 1); eb = mApBank;
    if (mAp > 0) mAp--;
    if (mLock > 0) mLock--;
    bo = 0; apo = 0;
    case (acc)
      1: begin mValid = 1; mBl = a[2:0]; mBt = a[3]; mCl = a[6:4]; mSw = a[9]; mLock = GAP - 1; end
      2: begin mAct[b] = 1; mRow[b] = a[10:0]; bo = b; end
      3, 4: begin bo = b; apo = a[10]; if (a[10]) begin mAp = len; mApBank = b; end end
      5: begin
        if (a[10]) begin mAct[0] = 0; mAct[1] = 0; mAp = 0; end
        else begin mAct[b] = 0; bo = b; if (b == eb) mAp = 0; end
      end
      default: ;
    endcase
    if (expire) mAct[eb] = 0;
    expQ.push_back('{tag, pack(3'(acc), !ok, bo, apo)});
  endtask

  task automatic nops(input string tag, input int n);
    for (int i = 0; i < n; i++) issue(tag, 1'b0, K_NOP, 12'h000);
  endtask

  // monitor: compares one expected record per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        logic [47:0] got;
        e = expQ.pop_front();
        got = actual();
        nCmp++;
        if (got !== e.vec) begin
          nBad++;
          $display("FAIL %s: got %h expected %h", e.tag, got, e.vec);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset("R13 reset");
    do_reset("R13 reset");
    issue("R1 deselect ignores mode load", 1'b1, K_MRS, 12'h022);
    issue("R1 nop", 1'b0, K_NOP, 12'hFFF);
    issue("R11 refresh when idle", 1'b0, K_REF, 12'h000);
    issue("R5 reserved A8:A7", 1'b0, K_MRS, 12'h0A2);
    issue("R5 reserved latency 0", 1'b0, K_MRS, 12'h002);
    issue("R5 full page interleaved", 1'b0, K_MRS, 12'h02F);
    issue("R4 mode load BL4 CL2", 1'b0, K_MRS, 12'h022);
    issue("R6 lockout after mode load", 1'b0, K_ACT, 12'h155);
    issue("R7 activate bank A", 1'b0, K_ACT, 12'h155);
    issue("R1 deselect", 1'b1, K_ACT, 12'h800);
    issue("R7 activate open bank", 1'b0, K_ACT, 12'h077);
    issue("R2 activate bank B", 1'b0, K_ACT, 12'hAAA);
    issue("R5 mode load with open bank", 1'b0, K_MRS, 12'h022);
    issue("R11 refresh with open bank", 1'b0, K_REF, 12'h000);
    issue("R3 read bank A", 1'b0, K_RD, 12'h005);
    issue("R3 write bank B", 1'b0, K_WR, 12'h803);
    issue("R2 burst stop", 1'b0, K_BST, 12'h000);
    issue("R8 precharge bank A", 1'b0, K_PRE, 12'h000);
    issue("R9 read idle bank", 1'b0, K_RD, 12'h001);
    issue("R12 write idle bank", 1'b0, K_WR, 12'h002);
    issue("R8 precharge all", 1'b0, K_PRE, 12'hC00);
    // auto precharge, burst length 4
    issue("R7 activate A", 1'b0, K_ACT, 12'h001);
    issue("R3 read auto precharge", 1'b0, K_RD, 12'h400);
    issue("R10 write in window", 1'b0, K_WR, 12'h000);
    nops("R10 window", 2);
    issue("R10 read at last edge", 1'b0, K_RD, 12'h000);
    issue("R10 activate after close", 1'b0, K_ACT, 12'h033);
    issue("R8 precharge all", 1'b0, K_PRE, 12'h400);
    // full page, single write, latency 3
    issue("R4 mode load full page single", 1'b0, K_MRS, 12'h237);
    issue("R1 nop", 1'b0, K_NOP, 12'h000);
    issue("R7 activate B", 1'b0, K_ACT, 12'h810);
    issue("R3 write B auto precharge", 1'b0, K_WR, 12'hC01);
    issue("R10 single write window", 1'b0, K_RD, 12'h800);
    issue("R9 read closed bank B", 1'b0, K_RD, 12'h800);
    issue("R7 activate A", 1'b0, K_ACT, 12'h044);
    issue("R10 read A full page auto", 1'b0, K_RD, 12'h400);
    nops("R10 window", 2);
    issue("R10 precharge ends window", 1'b0, K_PRE, 12'h000);
    issue("R7 reactivate A", 1'b0, K_ACT, 12'h055);
    issue("R10 read after window", 1'b0, K_RD, 12'h003);
    issue("R8 precharge all", 1'b0, K_PRE, 12'hC00);
    issue("R4 mode load interleaved BL8", 1'b0, K_MRS, 12'h02B);
    issue("R6 lockout refresh", 1'b0, K_REF, 12'h000);
    issue("R5 reserved length 4", 1'b0, K_MRS, 12'h024);
    issue("R12 illegal keeps mode", 1'b0, K_NOP, 12'h000);
    issue("R7 activate B", 1'b0, K_ACT, 12'h9FF);
    do_reset("R13 reset mid run");
    issue("R13 after reset", 1'b0, K_NOP, 12'h000);
    issue("R1 final", 1'b1, K_NOP, 12'h000);
    @(negedge clk);
    csN = 1'b1;
    while (expQ.size() > 0) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule